// File: doc/BRIEF.md
# MSI Vector Capture Controller

This block ends message-signalled interrupts at a root port. Software programs a 64-bit doorbell address into two 32-bit words. Any inbound memory write whose address equals that doorbell carries a vector number in its data word. If the vector is in range and enabled, the block records it as pending.

Vectors are grouped into banks of 32. Vector n belongs to bank n/32 at bit position n%32. Each bank has three registers:
- an enable word, which decides whether the vector can be captured;
- a mask word, which decides whether a pending vector may drive the interrupt line;
- a pending word, which software clears by writing ones.

A single level interrupt stays high while any vector is pending, enabled and unmasked. The interrupt handler reads the pending words to find the work, then writes ones to retire it.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset, every register reads 0 and irqOut is 0.
- R2: Offset 0x820 holds bits 31:0 and offset 0x824 holds bits 63:32 of the doorbell address. Both are written whole and read back as written.
- R3: Bank b occupies three offsets starting at 0x828 + 12*b: enable at +0, mask at +4, pending at +8. Enable and mask are written whole. Read data appears on regRdata in the cycle after regRdEn and then holds. Any other offset reads 0, and writes to it change no register.
- R4: An inbound write with msiWrValid high, address equal to the doorbell and data n sets pending bit n%32 of bank n/32 at the next clock, provided the enable bit of vector n is 1.
- R5: An inbound write whose address differs from the doorbell in either word sets no pending bit.
- R6: An inbound write for a vector whose enable bit is 0 sets no pending bit.
- R7: An inbound write whose data is 256 or more (with the default 8 banks) is ignored.
- R8: Writing the pending register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R9: When a capture and a clear hit the same pending bit in the same cycle, the bit ends up set.
- R10: irqOut is high exactly when some bank has a bit that is pending, enabled and not masked. It follows register changes in the same cycle they take effect.
- R11: A mask bit does not stop capture. It only holds irqOut low, and clearing the mask raises irqOut for a vector that is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 12 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, valid the cycle after regRdEn |
| msiWrValid | input | 1 | Inbound memory write valid |
| msiWrAddr | input | 64 | Inbound write address |
| msiWrData | input | 32 | Inbound write data (vector number) |
| irqOut | output | 1 | Level interrupt to the host |

## Verification
A wrong pending bit shows up on irqOut at the very next clock, unless the bit is masked or disabled. In that case it stays hidden until the pending word is read back, which a random mix of reads exposes within a few operations. A bad bank decode shows as a bit landing in, or being cleared from, a neighbouring bank. The bench compares whole words, so such an error is caught on the first read of either bank. The capture-versus-clear race is driven directly in one cycle, so a priority error becomes a lost interrupt visible on irqOut.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  localparam int BANK_IDX_W = 8;
  localparam int BANK_BITS  = 32;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_ADDR_LO,
    RD_ADDR_HI,
    RD_ENABLE,
    RD_MASK,
    RD_STATUS
  } rdKind_e;

  typedef struct packed {
    logic                  wrLo;
    logic                  wrHi;
    logic                  wrEnable;
    logic                  wrMask;
    logic                  wrStatus;
    logic                  rdStrobe;
    rdKind_e               rdKind;
    logic [BANK_IDX_W-1:0] regBank;
    logic [31:0]           wdata;
    logic                  capHit;
    logic [BANK_IDX_W-1:0] capBank;
    logic [4:0]            capBit;
  } ctrlStrobe_t;

endpackage

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
  import msi_cap_pkg::*;
#(
  parameter int NUM_BANKS   = 8,
  parameter int ADDR_W      = 12,
  parameter int ADDR_LO_OFS = 'h820,
  parameter int ADDR_HI_OFS = 'h824,
  parameter int BANK_BASE   = 'h828,
  parameter int BANK_STRIDE = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  input  logic              msiWrValid,
  input  logic [63:0]       msiWrAddr,
  input  logic [31:0]       msiWrData,
  input  logic [63:0]       targetAddr,
  output ctrlStrobe_t       st
);

  localparam int NUM_VECTORS = NUM_BANKS * BANK_BITS;

  rdKind_e kind;

  always_comb begin
    st       = '0;
    kind     = RD_NONE;
    st.wdata = regWdata;
    if (regAddr == ADDR_W'(ADDR_LO_OFS)) begin
      kind    = RD_ADDR_LO;
      st.wrLo = regWrEn;
    end
    if (regAddr == ADDR_W'(ADDR_HI_OFS)) begin
      kind    = RD_ADDR_HI;
      st.wrHi = regWrEn;
    end
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (regAddr == ADDR_W'(BANK_BASE + b * BANK_STRIDE)) begin
        kind        = RD_ENABLE;
        st.wrEnable = regWrEn;
        st.regBank  = BANK_IDX_W'(b);
      end
      if (regAddr == ADDR_W'(BANK_BASE + b * BANK_STRIDE + 4)) begin
        kind      = RD_MASK;
        st.wrMask = regWrEn;
        st.regBank = BANK_IDX_W'(b);
      end
      if (regAddr == ADDR_W'(BANK_BASE + b * BANK_STRIDE + 8)) begin
        kind        = RD_STATUS;
        st.wrStatus = regWrEn;
        st.regBank  = BANK_IDX_W'(b);
      end
    end
    st.rdStrobe = regRdEn;
    st.rdKind   = regRdEn ? kind : RD_NONE;

    st.capHit  = msiWrValid && (msiWrAddr == targetAddr) &&
                 (msiWrData < 32'(NUM_VECTORS));
    st.capBank = BANK_IDX_W'(msiWrData >> 5);
    st.capBit  = msiWrData[4:0];
  end

  AST_ONE_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st.wrLo, st.wrHi, st.wrEnable, st.wrMask, st.wrStatus})); // R3

  AST_CAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    st.capHit |-> (int'(st.capBank) < NUM_BANKS)); // R7

  AST_CAP_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    st.capHit |-> (msiWrValid && msiWrAddr == targetAddr)); // R5

endmodule

// File: rtl/msi_cap_dp.sv
module msi_cap_dp
  import msi_cap_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  ctrlStrobe_t st,
  output logic [63:0] targetAddr,
  output logic [31:0] regRdata,
  output logic        irqOut
);

  logic [31:0] tgtLo;
  logic [31:0] tgtHi;
  logic [31:0] enReg   [NUM_BANKS];
  logic [31:0] maskReg [NUM_BANKS];
  logic [31:0] statReg [NUM_BANKS];
  logic [NUM_BANKS-1:0] bankIrq;
  logic [31:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgtLo <= '0;
      tgtHi <= '0;
    end else begin
      if (st.wrLo) tgtLo <= st.wdata;
      if (st.wrHi) tgtHi <= st.wdata;
    end
  end

  assign targetAddr = {tgtHi, tgtLo};

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    logic        selReg;
    logic        selCap;
    logic [31:0] capVec;
    logic [31:0] clrVec;

    assign selReg = (st.regBank == BANK_IDX_W'(gb));
    assign selCap = st.capHit && (st.capBank == BANK_IDX_W'(gb));
    assign capVec = selCap ? ((32'd1 << st.capBit) & enReg[gb]) : '0;
    assign clrVec = (st.wrStatus && selReg) ? st.wdata : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        enReg[gb]   <= '0;
        maskReg[gb] <= '0;
        statReg[gb] <= '0;
      end else begin
        if (st.wrEnable && selReg) enReg[gb]   <= st.wdata;
        if (st.wrMask && selReg)   maskReg[gb] <= st.wdata;
        statReg[gb] <= (statReg[gb] & ~clrVec) | capVec;
      end
    end

    assign bankIrq[gb] = |(statReg[gb] & enReg[gb] & ~maskReg[gb]);

    AST_CAPTURE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (selCap && enReg[gb][st.capBit]) |=>
      ((statReg[gb] & $past(32'd1 << st.capBit)) != 0)); // R4

    AST_NO_SET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      ((statReg[gb] & ~$past(statReg[gb]) & ~$past(enReg[gb])) == 0)); // R6

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (st.wrStatus && selReg && !selCap) |=>
      ((statReg[gb] & $past(st.wdata)) == 0)); // R8

    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (selCap && enReg[gb][st.capBit] && st.wrStatus && selReg) |=>
      ((statReg[gb] & $past(32'd1 << st.capBit)) != 0)); // R9
  end

  always_comb begin
    rdNext = '0;
    case (st.rdKind)
      RD_ADDR_LO: rdNext = tgtLo;
      RD_ADDR_HI: rdNext = tgtHi;
      default: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (st.regBank == BANK_IDX_W'(b)) begin
            if (st.rdKind == RD_ENABLE) rdNext = enReg[b];
            if (st.rdKind == RD_MASK)   rdNext = maskReg[b];
            if (st.rdKind == RD_STATUS) rdNext = statReg[b];
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           regRdata <= '0;
    else if (st.rdStrobe) regRdata <= rdNext;
  end

  assign irqOut = |bankIrq;

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqOut) |-> $past(st.capHit || st.wrEnable || st.wrMask)); // R10

  AST_ADDR_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    st.wrLo |=> (targetAddr[31:0] == $past(st.wdata))); // R2

endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
  import msi_cap_pkg::*;
#(
  parameter int NUM_BANKS   = 8,
  parameter int ADDR_W      = 12,
  parameter int ADDR_LO_OFS = 'h820,
  parameter int ADDR_HI_OFS = 'h824,
  parameter int BANK_BASE   = 'h828,
  parameter int BANK_STRIDE = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              msiWrValid,
  input  logic [63:0]       msiWrAddr,
  input  logic [31:0]       msiWrData,
  output logic              irqOut
);

  ctrlStrobe_t st;
  logic [63:0] targetAddr;

  msi_cap_ctrl #(
    .NUM_BANKS  (NUM_BANKS),
    .ADDR_W     (ADDR_W),
    .ADDR_LO_OFS(ADDR_LO_OFS),
    .ADDR_HI_OFS(ADDR_HI_OFS),
    .BANK_BASE  (BANK_BASE),
    .BANK_STRIDE(BANK_STRIDE)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .msiWrValid(msiWrValid),
    .msiWrAddr (msiWrAddr),
    .msiWrData (msiWrData),
    .targetAddr(targetAddr),
    .st        (st)
  );

  msi_cap_dp #(
    .NUM_BANKS(NUM_BANKS)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .targetAddr(targetAddr),
    .regRdata  (regRdata),
    .irqOut    (irqOut)
  );

endmodule

// File: tb/sim_msi_capture_ctrl.sv
module sim_msi_capture_ctrl;

  localparam int NB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        msiWrValid = 1'b0;
  logic [63:0] msiWrAddr = '0;
  logic [31:0] msiWrData = '0;
  logic        irqOut;

  int nCompared = 0;
  int nMismatch = 0;

  logic [31:0] mLo = '0, mHi = '0;
  logic [31:0] mEn [NB];
  logic [31:0] mMask [NB];
  logic [31:0] mStat [NB];

  always #5 clk = ~clk;

  msi_capture_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .msiWrValid(msiWrValid), .msiWrAddr(msiWrAddr), .msiWrData(msiWrData),
    .irqOut(irqOut)
  );

  function automatic logic [11:0] bankOfs(int b, int k);
    return 12'('h828 + 12 * b + 4 * k);
  endfunction

  function automatic logic expIrq();
    logic r = 1'b0;
    for (int b = 0; b < NB; b++) r |= |(mStat[b] & mEn[b] & ~mMask[b]);
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatch++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic modelCapture(logic [63:0] a, logic [31:0] d);
    if (a == {mHi, mLo} && d < 32'(NB * 32) && mEn[d / 32][d % 32])
      mStat[d / 32][d % 32] = 1'b1;
  endtask

  task automatic modelWrite(logic [11:0] a, logic [31:0] d);
    if (a == 12'h820) mLo = d;
    if (a == 12'h824) mHi = d;
    for (int b = 0; b < NB; b++) begin
      if (a == bankOfs(b, 0)) mEn[b] = d;
      if (a == bankOfs(b, 1)) mMask[b] = d;
      if (a == bankOfs(b, 2)) mStat[b] = mStat[b] & ~d;
    end
  endtask

  task automatic regWrite(logic [11:0] a, logic [31:0] d);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic regRead(logic [11:0] a, output logic [31:0] v);
    regAddr = a; regRdEn = 1'b1;
    @(posedge clk); @(negedge clk);
    regRdEn = 1'b0;
    v = regRdata;
  endtask

  task automatic msiSend(logic [63:0] a, logic [31:0] d);
    msiWrAddr = a; msiWrData = d; msiWrValid = 1'b1;
    @(posedge clk); @(negedge clk);
    msiWrValid = 1'b0;
    modelCapture(a, d);
  endtask

  task automatic readCheck(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] v;
    regRead(a, v);
    check(req, v, exp);
  endtask

  task automatic checkAllStatus(string req);
    for (int b = 0; b < NB; b++) readCheck(req, bankOfs(b, 2), mStat[b]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nMismatch++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

  initial begin
    logic [63:0] tgt;
    logic [31:0] v;
    void'($urandom(32'd1234));
    for (int b = 0; b < NB; b++) begin mEn[b] = '0; mMask[b] = '0; mStat[b] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", irqOut, 1'b0);
    readCheck("R1 lo", 12'h820, 32'h0);
    readCheck("R1 en3", bankOfs(3, 0), 32'h0);
    readCheck("R1 stat7", bankOfs(7, 2), 32'h0);

    // R2 doorbell address
    tgt = 64'hFEDC_BA98_0000_1000;
    regWrite(12'h820, tgt[31:0]);
    regWrite(12'h824, tgt[63:32]);
    readCheck("R2 lo", 12'h820, tgt[31:0]);
    readCheck("R2 hi", 12'h824, tgt[63:32]);

    // R3 bank layout and unmapped offsets
    regWrite(bankOfs(0, 0), 32'hFFFF_FFFF);
    regWrite(bankOfs(7, 0), 32'h8000_0001);
    regWrite(bankOfs(5, 1), 32'h0000_5A5A);
    readCheck("R3 en0", bankOfs(0, 0), 32'hFFFF_FFFF);
    readCheck("R3 en7", bankOfs(7, 0), 32'h8000_0001);
    readCheck("R3 mask5", bankOfs(5, 1), 32'h0000_5A5A);
    readCheck("R3 mask4", bankOfs(4, 1), 32'h0);
    regWrite(12'h900, 32'hFFFF_FFFF);
    regWrite(12'h82A, 32'hFFFF_FFFF);
    readCheck("R3 unmapped", 12'h900, 32'h0);
    readCheck("R3 en1 untouched", bankOfs(1, 0), 32'h0);
    readCheck("R3 en0 untouched", bankOfs(0, 0), 32'hFFFF_FFFF);

    // R4, R10 capture of first and last vector
    msiSend(tgt, 32'd0);
    check("R10 irq after capture", irqOut, 1'b1);
    readCheck("R4 vec0", bankOfs(0, 2), 32'h1);
    msiSend(tgt, 32'd255);
    readCheck("R4 vec255", bankOfs(7, 2), 32'h8000_0000);

    // R5 address mismatch in either word
    msiSend(tgt ^ 64'h1_0000_0000, 32'd5);
    msiSend(tgt ^ 64'h4, 32'd6);
    readCheck("R5 no capture", bankOfs(0, 2), 32'h1);

    // R6 disabled vector
    msiSend(tgt, 32'd33);
    readCheck("R6 disabled", bankOfs(1, 2), 32'h0);

    // R7 out of range vectors
    msiSend(tgt, 32'd256);
    msiSend(tgt, 32'h0010_0000);
    checkAllStatus("R7 out of range");

    // R8 write-one-to-clear
    msiSend(tgt, 32'd3);
    msiSend(tgt, 32'd7);
    regWrite(bankOfs(0, 2), 32'h0000_0008);
    readCheck("R8 partial clear", bankOfs(0, 2), 32'h0000_0081);
    regWrite(bankOfs(7, 2), 32'h8000_0000);
    regWrite(bankOfs(0, 2), 32'hFFFF_FFFF);
    check("R10 irq after clear", irqOut, 1'b0);

    // R9 capture and clear of the same bit in one cycle
    msiWrAddr = tgt; msiWrData = 32'd9; msiWrValid = 1'b1;
    regAddr = bankOfs(0, 2); regWdata = 32'h0000_0200; regWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    msiWrValid = 1'b0; regWrEn = 1'b0;
    mStat[0] = mStat[0] | 32'h0000_0200;
    readCheck("R9 capture wins", bankOfs(0, 2), 32'h0000_0200);
    check("R9 irq kept", irqOut, 1'b1);
    regWrite(bankOfs(0, 2), 32'h0000_0200);

    // R11 mask holds irq low but not capture
    regWrite(bankOfs(2, 0), 32'h0000_0010);
    regWrite(bankOfs(2, 1), 32'h0000_0010);
    msiSend(tgt, 32'd68);
    check("R11 masked irq", irqOut, 1'b0);
    readCheck("R11 masked capture", bankOfs(2, 2), 32'h0000_0010);
    regWrite(bankOfs(2, 1), 32'h0);
    check("R11 unmask raises irq", irqOut, 1'b1);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      int b = $urandom_range(0, NB - 1);
      case (op)
        0: regWrite(bankOfs(b, 0), $urandom());
        1: regWrite(bankOfs(b, 1), $urandom() & $urandom());
        2: regWrite(bankOfs(b, 2), $urandom() & $urandom());
        3: msiSend(($urandom_range(0, 4) == 0) ? tgt ^ 64'(1 << $urandom_range(0, 63)) : tgt,
                   32'($urandom_range(0, 300)));
        default: msiSend(tgt, 32'($urandom_range(0, NB * 32 - 1)));
      endcase
      check("R10 random irq", irqOut, expIrq());
      if (i % 7 == 0) readCheck("R4 random status", bankOfs(b, 2), mStat[b]);
      if (i % 29 == 0) readCheck("R3 random enable", bankOfs(b, 0), mEn[b]);
    end
    checkAllStatus("R8 final status");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

endmodule